// File: doc/BRIEF.md
# Sleep Mode Entry and Wake Controller

This block sits next to a small processor pipeline and controls its deepest low-power state. It decodes the 16-bit instruction word being executed. When the sleep word arrives with no extension prefix before it, the block stalls fetch and runs out a fixed five-cycle entry sequence. It then drops the clock enable for the core and the peripherals. The block itself runs on an always-on clock.

Four sources wake the core: reset, the maskable interrupt request lines, NMI and a debug exception request. The interrupt, NMI and debug inputs are asynchronous, so each passes through a two-flop synchronizer first. Any pending interrupt line ends sleep, even when it is masked. On wake the block raises the clock enable again and sends the pipeline a one-cycle pulse. That pulse says either to take an exception, with its cause and interrupt number, or to resume at the instruction after the sleep word. Reset always restarts the core from scratch. A wake that arrives during the entry sequence cuts entry short, so the event is never lost.

Top module: `sleep_ctrl`

## Requirements
- R1: The block starts the entry sequence only when `instr_valid_i` is 1, `prefix_i` is 0 and `instr_i` equals 16'h0040. Any other word, an invalid word or a prefixed sleep word leaves `state_o` at 0.
- R2: `state_o` encodes 0 as running, 1 as entering and 2 as sleeping. After the rising edge that accepts the sleep word, `state_o` reads 1 for four sampled cycles and changes to 2 on the fifth edge, counting the accepting edge. Sleeping is reached only through entering.
- R3: `fetch_stall_o` is 1 whenever `state_o` is not 0.
- R4: `clk_en_o` is 0 for the whole time `state_o` is 2 and is 1 otherwise.
- R5: A wake input raised between clock edges produces the wake pulse on the third rising edge after it is raised. Any set bit of `irq_i` wakes the block, whatever the values of `irq_en_i` and `ie_i`.
- R6: On wake, `wake_take_o` pulses if `dbg_i` is set, if `nmi_i` is set, or if `ie_i` is 1 and some bit of `irq_i & irq_en_i` is set. Otherwise `wake_resume_o` pulses.
- R7: `wake_take_o` and `wake_resume_o` never go high together. Each is high for a single cycle, and `state_o` is 0 in that cycle.
- R8: In the pulse cycle, `wake_src_o` is 2 for debug, 1 for NMI and 0 for interrupt, and debug has priority over NMI, which has priority over interrupts. For an interrupt take, `wake_irq_id_o` holds the lowest index set in `irq_i & irq_en_i`.
- R9: A wake that becomes visible during entry ends entry at once. The pulse appears, `state_o` returns to 0, and `state_o` never reaches 2.
- R10: Taking `rst_ni` low at any time, sleep included, at once forces `state_o` to 0, `clk_en_o` to 1 and `fetch_stall_o` to 0, with no wake pulse.
- R11: Wake inputs that are raised while `state_o` is 0 produce no pulse and leave `state_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Instruction word is being executed this cycle |
| instr_i | input | 16 | Instruction word |
| prefix_i | input | 1 | An extension prefix came before this word |
| irq_i | input | NIRQ (8) | Asynchronous maskable interrupt requests |
| irq_en_i | input | NIRQ (8) | Per-line enables from the interrupt controller |
| ie_i | input | 1 | Core interrupt enable flag |
| nmi_i | input | 1 | Asynchronous non-maskable interrupt request |
| dbg_i | input | 1 | Asynchronous debug exception request |
| fetch_stall_o | output | 1 | Hold instruction fetch |
| clk_en_o | output | 1 | Enable for the core and peripheral clocks |
| wake_take_o | output | 1 | One-cycle pulse: take an exception on wake |
| wake_resume_o | output | 1 | One-cycle pulse: resume after the sleep word |
| wake_src_o | output | 2 | Wake cause: 0 interrupt, 1 NMI, 2 debug |
| wake_irq_id_o | output | 3 | Index of the interrupt to take |
| state_o | output | 2 | 0 running, 1 entering, 2 sleeping |

## Verification
A table of wake patterns covers these cases:
- A masked line and a line with `ie_i` clear, where a design that uses the enables as a wake filter would sleep forever.
- Several lines pending at once, where an encoder with the wrong priority would report the wrong interrupt number.
- NMI and debug together, and NMI with an enabled interrupt, where the wrong priority would report the wrong cause.

Directed tests cover the rest:
- A prefixed sleep word and a near-miss opcode, where a decoder that is too loose would stall the core.
- A debug request raised during entry, where a design that waits out entry first would drop clocks and then lose or delay the wake.
- Reset during sleep, where clocks must come back at once.
- Interrupts while running, where a design that wakes while awake would emit spurious resume pulses.

The exact edge counts for entry and for synchronizer latency are checked, so an extra or missing register shows up as a shifted pulse.

// File: rtl/sleep_pkg.sv
`timescale 1ns/1ps
package sleep_pkg;
  localparam int          INSTR_W  = 16;
  localparam logic [15:0] SLEEP_OP = 16'h0040;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2
  } state_e;

  typedef enum logic [1:0] {
    SRC_IRQ = 2'd0,
    SRC_NMI = 2'd1,
    SRC_DBG = 2'd2
  } src_e;
endpackage

// File: rtl/sleep_sync.sv
`timescale 1ns/1ps
module sleep_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sleep_decode.sv
`timescale 1ns/1ps
module sleep_decode
  import sleep_pkg::*;
(
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               prefix_i,
  output logic               hit_o
);
  // Sleep has no extended form, so a prefixed word is not a sleep
  assign hit_o = valid_i && !prefix_i && (instr_i == SLEEP_OP);
endmodule

// File: rtl/sleep_wake_arb.sv
`timescale 1ns/1ps
module sleep_wake_arb
  import sleep_pkg::*;
#(
  parameter int NIRQ = 8,
  parameter int ID_W = 3
) (
  input  logic [NIRQ-1:0] irq_s_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic            ie_i,
  input  logic            nmi_s_i,
  input  logic            dbg_s_i,
  output logic            wake_o,
  output logic            take_o,
  output src_e            src_o,
  output logic [ID_W-1:0] id_o
);
  logic [NIRQ-1:0] hit;
  logic            irq_take;

  assign hit      = irq_s_i & irq_en_i;
  assign irq_take = ie_i && (|hit);
  // Masking does not gate wake, only exception entry
  assign wake_o   = (|irq_s_i) || nmi_s_i || dbg_s_i;
  assign take_o   = dbg_s_i || nmi_s_i || irq_take;

  always_comb begin
    if (dbg_s_i)      src_o = SRC_DBG;
    else if (nmi_s_i) src_o = SRC_NMI;
    else              src_o = SRC_IRQ;
  end

  always_comb begin
    id_o = '0;
    for (int i = NIRQ-1; i >= 0; i--) begin
      if (hit[i]) id_o = ID_W'(i);
    end
  end
endmodule

// File: rtl/sleep_ctrl.sv
`timescale 1ns/1ps
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int NIRQ         = 8,
  parameter int ENTRY_CYCLES = 5,
  parameter int SYNC_STAGES  = 2,
  parameter int IRQ_ID_W     = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                instr_valid_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic                prefix_i,
  input  logic [NIRQ-1:0]     irq_i,
  input  logic [NIRQ-1:0]     irq_en_i,
  input  logic                ie_i,
  input  logic                nmi_i,
  input  logic                dbg_i,
  output logic                fetch_stall_o,
  output logic                clk_en_o,
  output logic                wake_take_o,
  output logic                wake_resume_o,
  output logic [1:0]          wake_src_o,
  output logic [IRQ_ID_W-1:0] wake_irq_id_o,
  output logic [1:0]          state_o
);
  localparam int             CNT_W    = (ENTRY_CYCLES > 2) ? $clog2(ENTRY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_CYCLES-2);
  localparam int             SYNC_W   = NIRQ + 2;

  state_e               state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 take_q, resume_q;
  src_e                 src_q;
  logic [IRQ_ID_W-1:0]  id_q;

  logic                 sleep_hit;
  logic [SYNC_W-1:0]    async_in, sync_out;
  logic [NIRQ-1:0]      irq_s;
  logic                 nmi_s, dbg_s;
  logic                 wake, take;
  src_e                 src;
  logic [IRQ_ID_W-1:0]  id;

  sleep_decode u_dec (
    .valid_i  (instr_valid_i),
    .instr_i  (instr_i),
    .prefix_i (prefix_i),
    .hit_o    (sleep_hit)
  );

  assign async_in = {dbg_i, nmi_i, irq_i};

  sleep_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_in),
    .q_o    (sync_out)
  );

  assign irq_s = sync_out[NIRQ-1:0];
  assign nmi_s = sync_out[NIRQ];
  assign dbg_s = sync_out[NIRQ+1];

  sleep_wake_arb #(.NIRQ(NIRQ), .ID_W(IRQ_ID_W)) u_arb (
    .irq_s_i  (irq_s),
    .irq_en_i (irq_en_i),
    .ie_i     (ie_i),
    .nmi_s_i  (nmi_s),
    .dbg_s_i  (dbg_s),
    .wake_o   (wake),
    .take_o   (take),
    .src_o    (src),
    .id_o     (id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      cnt_q    <= '0;
      take_q   <= 1'b0;
      resume_q <= 1'b0;
      src_q    <= SRC_IRQ;
      id_q     <= '0;
    end else begin
      take_q   <= 1'b0;
      resume_q <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          if (sleep_hit) begin
            state_q <= ST_ENTER;
            cnt_q   <= '0;
          end
        end
        ST_ENTER, ST_SLEEP: begin
          if (wake) begin
            // Wake during entry aborts the sequence
            state_q  <= ST_RUN;
            take_q   <= take;
            resume_q <= !take;
            src_q    <= src;
            id_q     <= id;
          end else if (state_q == ST_ENTER) begin
            if (cnt_q == CNT_LAST) state_q <= ST_SLEEP;
            else                   cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign fetch_stall_o = (state_q != ST_RUN);
  assign clk_en_o      = (state_q != ST_SLEEP);
  assign wake_take_o   = take_q;
  assign wake_resume_o = resume_q;
  assign wake_src_o    = src_q;
  assign wake_irq_id_o = id_q;
  assign state_o       = state_q;
endmodule

// File: rtl/sleep_ctrl_chk.sv
`timescale 1ns/1ps
module sleep_ctrl_chk #(
  parameter int ENTRY_CYCLES = 5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] state_o,
  input logic       clk_en_o,
  input logic       wake_take_o,
  input logic       wake_resume_o
);
  logic [7:0] ent_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ent_cnt <= '0;
    else if (state_o == 2'd1) ent_cnt <= (ent_cnt == 8'hff) ? ent_cnt : ent_cnt + 8'd1;
    else                      ent_cnt <= '0;
  end

  assert_entry_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && $past(state_o) == 2'd1) |-> (ent_cnt == 8'(ENTRY_CYCLES-1)));

  assert_sleep_via_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |-> ($past(state_o) != 2'd0));

  assert_clk_off_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && $past(state_o) == 2'd2) |-> (!clk_en_o && !$past(clk_en_o)));

  assert_pulse_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wake_take_o && wake_resume_o));

  assert_take_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_take_o |=> !wake_take_o);

  assert_resume_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_resume_o |=> !wake_resume_o);

  assert_wake_from_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_take_o || wake_resume_o) |-> ($past(state_o) != 2'd0 && state_o == 2'd0));
endmodule

bind sleep_ctrl sleep_ctrl_chk #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .state_o       (state_o),
  .clk_en_o      (clk_en_o),
  .wake_take_o   (wake_take_o),
  .wake_resume_o (wake_resume_o)
);

// File: tb/sleep_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        prefix_i = 1'b0;
  logic [7:0]  irq_i = '0, irq_en_i = '0;
  logic        ie_i = 1'b0, nmi_i = 1'b0, dbg_i = 1'b0;
  logic        fetch_stall_o, clk_en_o, wake_take_o, wake_resume_o;
  logic [1:0]  wake_src_o, state_o;
  logic [2:0]  wake_irq_id_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sleep_ctrl u_dut (.*);

  typedef struct packed {
    logic [7:0] irq;
    logic [7:0] en;
    logic       ie, nmi, dbg, take;
    logic [1:0] src;
    logic [2:0] id;
  } vec_t;

  // R5/R6/R8 wake patterns
  localparam vec_t VECS [0:8] = '{
    '{8'h01, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0},
    '{8'h04, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{8'h04, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0},
    '{8'h30, 8'h20, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 3'd5},
    '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 3'd0},
    '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 3'd0},
    '{8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 3'd0},
    '{8'h80, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 3'd0},
    '{8'h82, 8'hff, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 3'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic issue(input logic [15:0] w, input logic pfx, input logic v);
    @(negedge clk_i);
    instr_valid_i = v; instr_i = w; prefix_i = pfx;
    step();
    @(negedge clk_i);
    instr_valid_i = 1'b0; instr_i = '0; prefix_i = 1'b0;
  endtask

  task automatic release_all();
    @(negedge clk_i);
    irq_i = '0; irq_en_i = '0; ie_i = 1'b0; nmi_i = 1'b0; dbg_i = 1'b0;
    repeat (4) step();
  endtask

  task automatic enter_sleep(input bit full);
    issue(16'h0040, 1'b0, 1'b1);
    chk("R2 accepted", state_o, 2'd1);
    chk("R3 stall", fetch_stall_o, 1'b1);
    if (full) begin
      for (int c = 0; c < 3; c++) begin
        step();
        chk("R2 entering", state_o, 2'd1);
      end
      step();
      chk("R2 sleeping", state_o, 2'd2);
      chk("R4 clk off", clk_en_o, 1'b0);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R10 reset state", state_o, 2'd0);
    chk("R10 reset clk_en", clk_en_o, 1'b1);
    chk("R10 reset stall", fetch_stall_o, 1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    step();

    for (int k = 0; k < 9; k++) begin
      vec_t v = VECS[k];
      enter_sleep(1'b1);
      @(negedge clk_i);
      irq_i = v.irq; irq_en_i = v.en; ie_i = v.ie; nmi_i = v.nmi; dbg_i = v.dbg;
      step(); step();
      chk("R5 still asleep", state_o, 2'd2);
      step();
      chk("R5 woke", state_o, 2'd0);
      chk("R4 clk back", clk_en_o, 1'b1);
      chk("R6 take", wake_take_o, v.take);
      chk("R6 resume", wake_resume_o, !v.take);
      if (v.take) chk("R8 src", wake_src_o, v.src);
      if (v.take && v.src == 2'd0) chk("R8 id", wake_irq_id_o, v.id);
      step();
      chk("R7 single pulse", {wake_take_o, wake_resume_o}, 2'b00);
      release_all();
    end

    // R1 decode negatives
    issue(16'h0040, 1'b1, 1'b1);
    chk("R1 prefixed ignored", state_o, 2'd0);
    step();
    chk("R1 prefixed ignored", fetch_stall_o, 1'b0);
    issue(16'h0041, 1'b0, 1'b1);
    chk("R1 other word", state_o, 2'd0);
    issue(16'h0040, 1'b0, 1'b0);
    chk("R1 not valid", state_o, 2'd0);

    // R11 wake sources while running
    @(negedge clk_i);
    irq_i = 8'h01; irq_en_i = 8'h01; ie_i = 1'b1; nmi_i = 1'b1;
    for (int c = 0; c < 4; c++) begin
      step();
      chk("R11 no pulse", {wake_take_o, wake_resume_o}, 2'b00);
      chk("R11 running", state_o, 2'd0);
    end
    release_all();

    // R9 debug during entry
    enter_sleep(1'b0);
    @(negedge clk_i);
    dbg_i = 1'b1;
    step();
    chk("R9 entering", state_o, 2'd1);
    step();
    chk("R9 entering", state_o, 2'd1);
    step();
    chk("R9 aborted", state_o, 2'd0);
    chk("R9 take", wake_take_o, 1'b1);
    chk("R9 src dbg", wake_src_o, 2'd2);
    step();
    chk("R9 never slept", state_o, 2'd0);
    release_all();

    // R10 reset during sleep
    enter_sleep(1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R10 state", state_o, 2'd0);
    chk("R10 clk_en", clk_en_o, 1'b1);
    chk("R10 stall", fetch_stall_o, 1'b0);
    chk("R10 no pulse", {wake_take_o, wake_resume_o}, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk("R10 stays running", state_o, 2'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule